// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an operand specifier into a memory address for a processor whose address registers are eight 32-bit words. It holds those registers. Each cycle it reads the selected register and works out three things: whether the operand is the register itself or a location in memory, the 24-bit memory address, and, for the auto-stepping modes, the updated register value that is written back at the next clock edge.

A separate write port loads a register from the rest of the datapath, for example after an arithmetic result. The address, the register-operand flag and the read data are combinational in the current inputs and the current register contents. The write-back enable and the error flags apply only while `valid_i` is high. When a word or longword access falls on an odd address, an error flag is raised. The access still goes ahead: the address is driven and the write-back still takes place.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (register direct) sets `is_reg_o`=1 and `addr_o`=0, never writes back, and shows the selected register on `reg_data_o`. In every mode `reg_data_o` is the selected register's 32-bit content before any update.
- R2: Mode code 1 (indirect) drives `addr_o` with bits 23:0 of the selected register.
- R3: Mode code 2 adds `disp_i[15:0]`, sign-extended to 24 bits, to bits 23:0 of the register. The sum wraps modulo 2^24.
- R4: Mode code 3 adds `disp_i[23:0]` unchanged, with no sign extension, to bits 23:0 of the register. The sum wraps modulo 2^24.
- R5: Mode code 4 (post-increment) drives `addr_o` with bits 23:0 of the register before the update. It sets `wb_data_o` to register + step, wrapping modulo 2^32, and that value is stored at the next rising edge.
- R6: Mode code 5 (pre-decrement) sets `wb_data_o` to register − step, wrapping modulo 2^32. `addr_o` is bits 23:0 of that new value, and the new value is stored at the next rising edge.
- R7: The step comes from `size_i`: 0 (byte) steps by 1, 1 (word) by 2, and 2 or 3 (longword) by 4.
- R8: `align_err_o` is 1 only when `valid_i` is high, the mode is 1 to 5, `size_i` is non-zero and `addr_o[0]` is 1. In that case the address and the write-back are unaffected.
- R9: Mode codes 6 and 7 set `illegal_o` while `valid_i` is high, force `addr_o` to 0 and `is_reg_o` to 0, and never write back.
- R10: No register changes through the stepping path unless `valid_i` is high. With `valid_i` low, `wb_en_o`, `align_err_o` and `illegal_o` are all 0.
- R11: While `rst_ni` is low, all eight registers clear to zero.
- R12: `ld_en_i` writes `ld_data_i` into register `ld_idx_i` at the rising edge. If a write-back targets the same register in that cycle, the write-back value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand request strobe |
| mode_i | input | 3 | Addressing mode code |
| reg_idx_i | input | 3 | Address register index |
| size_i | input | 2 | Operand size code |
| disp_i | input | 24 | Displacement |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 3 | Register load index |
| ld_data_i | input | 32 | Register load data |
| addr_o | output | 24 | Memory operand address |
| is_reg_o | output | 1 | Operand is the register itself |
| reg_data_o | output | 32 | Selected register content |
| wb_en_o | output | 1 | Write-back enable |
| wb_data_o | output | 32 | Write-back value |
| align_err_o | output | 1 | Odd word/longword address |
| illegal_o | output | 1 | Unused mode code |

## Verification
The bench uses the default parameters: eight registers, 32-bit register width and 24-bit addresses. With these values the boundary cases can be reached directly. A 16-bit displacement with its top bit set is added to a register near the top of the 24-bit space. A 24-bit displacement has bit 23 set. Stepping crosses both the 32-bit and the 24-bit boundaries, starting from all-ones and from zero. The bench also runs byte, word and longword steps in a row so that the low address bit alternates, and it covers a load colliding with a write-back to the same register.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    EA_DIR  = 3'd0,
    EA_IND  = 3'd1,
    EA_D16  = 3'd2,
    EA_D24  = 3'd3,
    EA_PINC = 3'd4,
    EA_PDEC = 3'd5
  } ea_mode_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wb_en_i,
  input  logic [IW-1:0] wb_idx_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic          ld_en_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [DW-1:0] ld_data_i
);
  logic [DW-1:0] regs_q [NREG];

  // write-back has priority over load on the same index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wb_en_i && wb_idx_i == IW'(i))      regs_q[i] <= wb_data_i;
        else if (ld_en_i && ld_idx_i == IW'(i)) regs_q[i] <= ld_data_i;
      end
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];

  p_wb_lands_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |=> regs_q[$past(wb_idx_i)] == $past(wb_data_i));
  p_ld_lands_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !wb_en_i) |=> regs_q[$past(ld_idx_i)] == $past(ld_data_i));
endmodule

// File: rtl/ea_step.sv
module ea_step #(
  parameter int DW = 32
) (
  input  logic [1:0]    size_i,
  output logic [DW-1:0] step_o,
  output logic          wide_o
);
  import ea_pkg::*;
  always_comb begin
    unique case (size_i)
      SZ_BYTE: step_o = DW'(1);
      SZ_WORD: step_o = DW'(2);
      default: step_o = DW'(4);
    endcase
  end
  assign wide_o = (size_i != SZ_BYTE);
endmodule

// File: rtl/ea_addr.sv
module ea_addr #(
  parameter int DW = 32,
  parameter int AW = 24
) (
  input  logic [2:0]    mode_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] step_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wb_data_o,
  output logic          wb_req_o,
  output logic          is_reg_o,
  output logic          mem_o,
  output logic          bad_o
);
  import ea_pkg::*;
  localparam int SW = 16;

  logic [AW-1:0] base;
  logic [AW-1:0] d16_ext;
  logic [DW-1:0] inc_v, dec_v;

  assign base    = reg_i[AW-1:0];
  assign d16_ext = {{(AW-SW){disp_i[SW-1]}}, disp_i[SW-1:0]};
  assign inc_v   = reg_i + step_i;
  assign dec_v   = reg_i - step_i;

  always_comb begin
    addr_o    = '0;
    wb_data_o = '0;
    wb_req_o  = 1'b0;
    is_reg_o  = 1'b0;
    mem_o     = 1'b0;
    bad_o     = 1'b0;
    case (mode_i)
      EA_DIR:  is_reg_o = 1'b1;
      EA_IND:  begin addr_o = base;           mem_o = 1'b1; end
      EA_D16:  begin addr_o = base + d16_ext; mem_o = 1'b1; end
      EA_D24:  begin addr_o = base + disp_i;  mem_o = 1'b1; end
      EA_PINC: begin
        addr_o = base; wb_data_o = inc_v; wb_req_o = 1'b1; mem_o = 1'b1;
      end
      EA_PDEC: begin
        addr_o = dec_v[AW-1:0]; wb_data_o = dec_v; wb_req_o = 1'b1; mem_o = 1'b1;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int AW   = 24,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    mode_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] disp_i,
  input  logic          ld_en_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [DW-1:0] ld_data_i,
  output logic [AW-1:0] addr_o,
  output logic          is_reg_o,
  output logic [DW-1:0] reg_data_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_data_o,
  output logic          align_err_o,
  output logic          illegal_o
);
  import ea_pkg::*;

  logic [DW-1:0] step;
  logic          wide, wb_req, mem, bad;

  ea_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .rd_idx_i (reg_idx_i),
    .rd_data_o(reg_data_o),
    .wb_en_i  (wb_en_o),
    .wb_idx_i (reg_idx_i),
    .wb_data_i(wb_data_o),
    .ld_en_i, .ld_idx_i, .ld_data_i
  );

  ea_step #(.DW(DW)) u_step (.size_i, .step_o(step), .wide_o(wide));

  ea_addr #(.DW(DW), .AW(AW)) u_addr (
    .mode_i, .reg_i(reg_data_o), .step_i(step), .disp_i,
    .addr_o, .wb_data_o, .wb_req_o(wb_req), .is_reg_o, .mem_o(mem), .bad_o(bad)
  );

  assign wb_en_o     = valid_i && wb_req;
  assign illegal_o   = valid_i && bad;
  assign align_err_o = valid_i && mem && wide && addr_o[0];

  p_direct_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg_o |-> (!wb_en_o && !align_err_o && addr_o == '0));
  p_pinc_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && mode_i == EA_PINC) |-> (wb_data_o - reg_data_o == step));
  p_pdec_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && mode_i == EA_PDEC) |-> (addr_o == wb_data_o[AW-1:0] && reg_data_o - wb_data_o == step));
  p_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> (addr_o[0] && size_i != 2'd0 && valid_i));
  p_illegal_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && !is_reg_o && addr_o == '0));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !ld_en_i) |=> $stable(reg_data_o) || $past(reg_idx_i) != reg_idx_i);
endmodule

// File: tb/tb_ea_unit.sv
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_idx_i = '0;
  logic [1:0]  size_i = '0;
  logic [23:0] disp_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [23:0] addr_o;
  logic        is_reg_o, wb_en_o, align_err_o, illegal_o;
  logic [31:0] reg_data_o, wb_data_o;

  ea_unit dut (
    .clk_i(clk), .rst_ni, .valid_i, .mode_i, .reg_idx_i, .size_i, .disp_i,
    .ld_en_i, .ld_idx_i, .ld_data_i, .addr_o, .is_reg_o, .reg_data_o,
    .wb_en_o, .wb_data_o, .align_err_o, .illegal_o
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [23:0] addr;
    logic        is_reg;
    logic [31:0] rdata;
    logic        wb_en;
    logic [31:0] wb_data;
    logic        align;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mdl [8];
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  task automatic drive(input bit v, input logic [2:0] m, input logic [2:0] idx,
                       input logic [1:0] sz, input logic [23:0] d, input string tag,
                       input bit ld = 1'b0, input logic [2:0] lidx = '0,
                       input logic [31:0] ldat = '0);
    exp_t e;
    logic [31:0] r, st;
    @(negedge clk);
    valid_i = v; mode_i = m; reg_idx_i = idx; size_i = sz; disp_i = d;
    ld_en_i = ld; ld_idx_i = lidx; ld_data_i = ldat;
    r  = mdl[idx];
    st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    e.addr = '0; e.wb_data = '0; e.is_reg = (m == 3'd0); e.rdata = r;
    case (m)
      3'd1: e.addr = r[23:0];
      3'd2: e.addr = r[23:0] + {{8{d[15]}}, d[15:0]};
      3'd3: e.addr = r[23:0] + d;
      3'd4: begin e.addr = r[23:0]; e.wb_data = r + st; end
      3'd5: begin e.wb_data = r - st; e.addr = e.wb_data[23:0]; end
      default: ;
    endcase
    e.wb_en = v && (m == 3'd4 || m == 3'd5);
    e.ill   = v && (m >= 3'd6);
    e.align = v && (m >= 3'd1 && m <= 3'd5) && (sz != 2'd0) && e.addr[0];
    e.tag   = tag;
    q.push_back(e);
    if (ld) mdl[lidx] = ldat;
    if (e.wb_en) mdl[idx] = e.wb_data;
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    valid_i = 1'b0; ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = val;
    mdl[idx] = val;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0; ld_en_i = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (addr_o !== e.addr || is_reg_o !== e.is_reg || reg_data_o !== e.rdata ||
            wb_en_o !== e.wb_en || (e.wb_en && wb_data_o !== e.wb_data) ||
            align_err_o !== e.align || illegal_o !== e.ill) begin
          n_fail++;
          $display("FAIL %s: got addr=%h reg=%b rd=%h wb=%b/%h al=%b il=%b exp addr=%h reg=%b rd=%h wb=%b/%h al=%b il=%b",
                   e.tag, addr_o, is_reg_o, reg_data_o, wb_en_o, wb_data_o, align_err_o, illegal_o,
                   e.addr, e.is_reg, e.rdata, e.wb_en, e.wb_data, e.align, e.ill);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) drive(1, 3'd0, 3'(i), 2'd2, '0, "R11 reset zero / R1 direct");
    load(3'd1, 32'h1234_5678);
    drive(1, 3'd0, 3'd1, 2'd0, '0, "R1 direct read");
    drive(1, 3'd1, 3'd1, 2'd0, '0, "R2 indirect");
    load(3'd2, 32'h00FF_FFF0);
    drive(1, 3'd2, 3'd2, 2'd0, 24'h00_0020, "R3 disp16 wrap");
    drive(1, 3'd2, 3'd2, 2'd0, 24'hAB_8000, "R3 disp16 negative");
    drive(1, 3'd3, 3'd1, 2'd0, 24'h80_0000, "R4 disp24 no sign ext");
    drive(1, 3'd3, 3'd2, 2'd0, 24'h00_0011, "R4 disp24 wrap");
    load(3'd3, 32'h0000_0010);
    drive(1, 3'd4, 3'd3, 2'd0, '0, "R5 R7 pinc byte");
    drive(1, 3'd4, 3'd3, 2'd1, '0, "R8 R7 pinc word odd");
    drive(1, 3'd4, 3'd3, 2'd2, '0, "R8 R7 pinc long odd");
    drive(1, 3'd0, 3'd3, 2'd0, '0, "R5 writeback landed");
    load(3'd4, 32'h0000_0100);
    drive(1, 3'd5, 3'd4, 2'd2, '0, "R6 R7 pdec long");
    drive(1, 3'd5, 3'd4, 2'd1, '0, "R6 R7 pdec word");
    drive(1, 3'd5, 3'd4, 2'd0, '0, "R6 pdec byte");
    drive(1, 3'd5, 3'd4, 2'd1, '0, "R8 pdec word odd");
    drive(1, 3'd0, 3'd4, 2'd0, '0, "R6 writeback landed");
    load(3'd5, 32'hFFFF_FFFF);
    drive(1, 3'd4, 3'd5, 2'd0, '0, "R5 32-bit wrap");
    drive(1, 3'd0, 3'd5, 2'd0, '0, "R5 wrapped value");
    drive(1, 3'd5, 3'd6, 2'd3, '0, "R6 R7 size3 long from zero");
    drive(1, 3'd0, 3'd6, 2'd0, '0, "R6 wrapped value");
    drive(1, 3'd2, 3'd1, 2'd0, 24'h00_0001, "R8 odd byte no error");
    drive(0, 3'd4, 3'd6, 2'd2, '0, "R10 valid low no step");
    drive(0, 3'd1, 3'd1, 2'd1, 24'h0, "R10 valid low flags");
    drive(1, 3'd0, 3'd6, 2'd0, '0, "R10 value unchanged");
    drive(1, 3'd6, 3'd1, 2'd0, '0, "R9 illegal 6");
    drive(1, 3'd7, 3'd1, 2'd2, '0, "R9 illegal 7");
    drive(1, 3'd0, 3'd1, 2'd0, '0, "R9 no change");
    drive(1, 3'd4, 3'd7, 2'd2, '0, "R12 wb vs load", 1'b1, 3'd7, 32'hDEAD_BEEF);
    drive(1, 3'd0, 3'd7, 2'd0, '0, "R12 wb wins");
    drive(1, 3'd0, 3'd0, 2'd0, '0, "R12 load other", 1'b1, 3'd0, 32'h0000_0ACE);
    drive(1, 3'd0, 3'd0, 2'd0, '0, "R12 load landed");
    do_reset();
    for (int i = 0; i < 8; i++) drive(1, 3'd0, 3'(i), 2'd0, '0, "R11 mid-run reset");
    drive(0, 3'd0, 3'd0, 2'd0, '0, "drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule